// File: doc/BRIEF.md
# Address Translation Buffer with Page-Table Refill

This block turns a virtual byte address into a physical byte address. Pages are 4 KB, so the low 12 address bits pass through unchanged and the upper bits form the virtual page number. A four-entry translation buffer is searched first. On a miss, an on-chip page table is consulted, indexed by the virtual page number. If that page-table entry is valid, the translation is returned and written into the least recently used buffer entry. If the entry is invalid, or the page number is beyond the table, the lookup is reported as a page fault.

A parameter selects how the buffer is organised. It can be fully associative, with a rank list recording recency. It can also be 2-way set-associative, with two sets and one recency bit per set. A load port fills the page table one entry per cycle. An initialization port presets any buffer entry together with its recency.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. All buffer and page-table entries are invalid, so the first lookup reports a fault. The fully associative rank of entry i is i. In set mode, way 1 of each set is the least recently used way.
- R2: A request accepted while the buffer holds a matching valid entry gives `rsp_valid`=1 on the next cycle. The response carries code 00 and `rsp_paddr` = {entry page number, offset}.
- R3: A buffer miss with a valid page-table entry gives the response two cycles after acceptance. The response carries code 01 and the page-table page number. `rsp_valid` and `req_ready` are both 0 in the cycle between acceptance and response.
- R4: A buffer miss with an invalid page-table entry responds two cycles after acceptance with code 10 and `rsp_paddr` = 0. The buffer contents and recency state are left unchanged.
- R5: The low 12 bits of `rsp_paddr` equal the low 12 bits of the request address for codes 00 and 01.
- R6: Fully associative mode compares the whole page number against all four entries. A hit or a refill gives the touched entry rank 0 and adds one to every rank that was below its old rank. A refill replaces the entry of rank 3.
- R7: In set mode, page-number bit 0 selects set 0 (entries 0 and 1) or set 1 (entries 2 and 3). The tag is the page number shifted right by one bit. A touch makes the other way of the set the least recently used way, and a refill replaces the least recently used way.
- R8: A page number equal to or above the page-table depth (16) is reported as a fault.
- R9: An initialization write presets the valid bit, tag and page number of one entry. In fully associative mode it also sets that entry's rank. In set mode, a nonzero rank makes that way the set's least recently used way, and a zero rank makes the other way the least recently used way.
- R10: A request is ignored while `req_ready` is 0, that is, while a miss is pending or `init_we` is high.
- R11: A page-table load writes the valid bit and page number of one entry per cycle. Later misses on that page use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual byte address |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 00 buffer hit, 01 page-table hit, 10 fault |
| rsp_paddr | output | PPN_W+12 | Physical byte address (0 on fault) |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | clog2(PT_DEPTH) | Page-table entry index |
| pt_valid | input | 1 | Valid bit written to the page table |
| pt_ppn | input | PPN_W | Physical page number written to the page table |
| init_we | input | 1 | Buffer preset strobe |
| init_entry | input | 2 | Buffer entry to preset |
| init_valid | input | 1 | Valid bit for the preset entry |
| init_tag | input | VA_W-12 | Tag for the preset entry |
| init_ppn | input | PPN_W | Physical page number for the preset entry |
| init_rank | input | 2 | Recency preset (rank, or way recency in set mode) |

## Verification
A buffer hit is due one cycle after the accepting edge. A miss responds two cycles after that edge, with the response strobe and ready both low in the cycle between. The bench drives on falling edges and samples on the falling edge that follows each due rising edge. In the busy cycle of every miss it checks that no response has appeared, and it drives a decoy request that must be ignored. A cycle after each miss response it confirms that no further response follows. A bench-side model of both organisations predicts every code and address, so any recency or refill error appears as a wrong outcome on a later lookup.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W = 32,
  parameter int PPN_W = 8,
  parameter int PT_DEPTH = 16,
  parameter bit SET_ASSOC = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [VA_W-1:0]             req_vaddr,
  output logic                        req_ready,
  output logic                        rsp_valid,
  output logic [1:0]                  rsp_code,
  output logic [PPN_W+11:0]           rsp_paddr,
  input  logic                        pt_we,
  input  logic [$clog2(PT_DEPTH)-1:0] pt_idx,
  input  logic                        pt_valid,
  input  logic [PPN_W-1:0]            pt_ppn,
  input  logic                        init_we,
  input  logic [1:0]                  init_entry,
  input  logic                        init_valid,
  input  logic [VA_W-13:0]            init_tag,
  input  logic [PPN_W-1:0]            init_ppn,
  input  logic [1:0]                  init_rank
);
  localparam int VPN_W = VA_W - 12;
  localparam int PT_IW = $clog2(PT_DEPTH);

  logic [3:0]       e_v;
  logic [VPN_W-1:0] e_tag  [4];
  logic [PPN_W-1:0] e_ppn  [4];
  logic [1:0]       e_rank [4];
  logic [1:0]       set_lru;
  logic             pt_v   [PT_DEPTH];
  logic [PPN_W-1:0] pt_p   [PT_DEPTH];
  logic             pend;
  logic [VPN_W-1:0] p_vpn;
  logic [11:0]      p_off;

  wire [VPN_W-1:0] vpn = req_vaddr[VA_W-1:12];
  wire [VPN_W-1:0] cmp_tag = SET_ASSOC ? {1'b0, vpn[VPN_W-1:1]} : vpn;
  wire [VPN_W-1:0] p_tag = SET_ASSOC ? {1'b0, p_vpn[VPN_W-1:1]} : p_vpn;

  logic [3:0] hit_vec;
  for (genvar i = 0; i < 4; i++) begin : g_cmp
    assign hit_vec[i] = e_v[i] && (e_tag[i] == cmp_tag) &&
                        ((SET_ASSOC == 1'b0) || (vpn[0] == 1'(i / 2)));
  end

  logic [1:0] hit_idx, fa_vic;
  always_comb begin
    hit_idx = 2'd0;
    for (int i = 3; i >= 0; i--) if (hit_vec[i]) hit_idx = 2'(i);
    fa_vic = 2'd0;
    for (int i = 0; i < 4; i++) if (e_rank[i] == 2'd3) fa_vic = 2'(i);
  end

  wire any_hit = |hit_vec;
  assign req_ready = !pend && !init_we;
  wire accept = req_valid && req_ready;
  wire in_range = p_vpn < VPN_W'(PT_DEPTH);
  wire pt_hit = in_range && pt_v[p_vpn[PT_IW-1:0]];
  wire [PPN_W-1:0] pt_ppn_rd = pt_p[p_vpn[PT_IW-1:0]];
  wire [1:0] victim = SET_ASSOC ? {p_vpn[0], set_lru[p_vpn[0]]} : fa_vic;
  wire touch_en = (accept && any_hit) || (pend && pt_hit);
  wire [1:0] touch_idx = pend ? victim : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v       <= '0;
      set_lru   <= 2'b11;
      pend      <= 1'b0;
      p_vpn     <= '0;
      p_off     <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= 2'b00;
      rsp_paddr <= '0;
      for (int j = 0; j < 4; j++) begin
        e_tag[j]  <= '0;
        e_ppn[j]  <= '0;
        e_rank[j] <= 2'(j);
      end
      for (int j = 0; j < PT_DEPTH; j++) begin
        pt_v[j] <= 1'b0;
        pt_p[j] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (pt_we) begin
        pt_v[pt_idx] <= pt_valid;
        pt_p[pt_idx] <= pt_ppn;
      end
      if (accept && any_hit) begin
        rsp_valid <= 1'b1;
        rsp_code  <= 2'b00;
        rsp_paddr <= {e_ppn[hit_idx], req_vaddr[11:0]};
      end else if (accept) begin
        pend  <= 1'b1;
        p_vpn <= vpn;
        p_off <= req_vaddr[11:0];
      end
      if (pend) begin
        pend      <= 1'b0;
        rsp_valid <= 1'b1;
        if (pt_hit) begin
          rsp_code          <= 2'b01;
          rsp_paddr         <= {pt_ppn_rd, p_off};
          e_v[victim]       <= 1'b1;
          e_tag[victim]     <= p_tag;
          e_ppn[victim]     <= pt_ppn_rd;
        end else begin
          rsp_code  <= 2'b10;
          rsp_paddr <= '0;
        end
      end
      if (touch_en) begin
        if (SET_ASSOC) set_lru[touch_idx[1]] <= ~touch_idx[0];
        else begin
          for (int j = 0; j < 4; j++)
            if (e_rank[j] < e_rank[touch_idx]) e_rank[j] <= e_rank[j] + 2'd1;
          e_rank[touch_idx] <= 2'd0;
        end
      end
      if (init_we) begin
        e_v[init_entry]   <= init_valid;
        e_tag[init_entry] <= init_tag;
        e_ppn[init_entry] <= init_ppn;
        if (SET_ASSOC)
          set_lru[init_entry[1]] <= (init_rank != 2'd0) ? init_entry[0] : ~init_entry[0];
        else
          e_rank[init_entry] <= init_rank;
      end
    end
  end

  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code != 2'b11);
  a_r2_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_hit) |=> (rsp_valid && rsp_code == 2'b00));
  a_r3_miss_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> (!rsp_valid && !req_ready));
  a_r3_miss_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> ##1 (rsp_valid && rsp_code != 2'b00));
  a_r4_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pt_hit && !init_we) |=> ($stable(e_v) && $stable(set_lru)));
  a_r5_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_hit) |=> rsp_paddr[11:0] == $past(req_vaddr[11:0]));
endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rv [2];
  logic [31:0] va [2];
  logic        rdy [2];
  logic        rspv [2];
  logic [1:0]  code [2];
  logic [19:0] pa [2];
  logic        pt_we = 1'b0, pt_valid = 1'b0, init_we = 1'b0, init_valid = 1'b0;
  logic [3:0]  pt_idx = '0;
  logic [7:0]  pt_ppn = '0, init_ppn = '0;
  logic [1:0]  init_entry = '0, init_rank = '0;
  logic [19:0] init_tag = '0;

  tlb_xlate #(.SET_ASSOC(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_vaddr(va[0]), .req_ready(rdy[0]),
    .rsp_valid(rspv[0]), .rsp_code(code[0]), .rsp_paddr(pa[0]),
    .pt_we(pt_we), .pt_idx(pt_idx), .pt_valid(pt_valid), .pt_ppn(pt_ppn),
    .init_we(init_we), .init_entry(init_entry), .init_valid(init_valid),
    .init_tag(init_tag), .init_ppn(init_ppn), .init_rank(init_rank));

  tlb_xlate #(.SET_ASSOC(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_vaddr(va[1]), .req_ready(rdy[1]),
    .rsp_valid(rspv[1]), .rsp_code(code[1]), .rsp_paddr(pa[1]),
    .pt_we(pt_we), .pt_idx(pt_idx), .pt_valid(pt_valid), .pt_ppn(pt_ppn),
    .init_we(init_we), .init_entry(init_entry), .init_valid(init_valid),
    .init_tag(init_tag), .init_ppn(init_ppn), .init_rank(init_rank));

  int checks = 0, errors = 0;
  int bv [2][4], btag [2][4], bppn [2][4], brank [2][4], blru [2][2];
  int ptv [16], ptp [16];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic touch(input int m, input int i);
    if (m == 1) blru[1][i / 2] = 1 - (i % 2);
    else begin
      int r = brank[0][i];
      for (int j = 0; j < 4; j++) if (brank[0][j] < r) brank[0][j]++;
      brank[0][i] = 0;
    end
  endtask

  task automatic model(input int m, input int vpn, output int c, output int p);
    int tag = (m == 1) ? vpn / 2 : vpn;
    int lo = (m == 1) ? 2 * (vpn % 2) : 0;
    int hi = (m == 1) ? lo + 1 : 3;
    int hit = -1;
    for (int i = hi; i >= lo; i--) if (bv[m][i] != 0 && btag[m][i] == tag) hit = i;
    if (hit >= 0) begin
      c = 0; p = bppn[m][hit]; touch(m, hit);
    end else if (vpn < 16 && ptv[vpn] != 0) begin
      int vic = 0;
      if (m == 1) vic = lo + blru[1][vpn % 2];
      else for (int j = 0; j < 4; j++) if (brank[0][j] == 3) vic = j;
      bv[m][vic] = 1; btag[m][vic] = tag; bppn[m][vic] = ptp[vpn];
      touch(m, vic);
      c = 1; p = ptp[vpn];
    end else begin
      c = 2; p = 0;
    end
  endtask

  task automatic pt_load(input int i, input int v, input int p);
    @(negedge clk);
    pt_we = 1'b1; pt_idx = 4'(i); pt_valid = 1'(v); pt_ppn = 8'(p);
    ptv[i] = v; ptp[i] = p;
    @(negedge clk);
    pt_we = 1'b0;
  endtask

  task automatic init_ent(input int e, input int v, input int tag, input int p, input int rank);
    @(negedge clk);
    init_we = 1'b1; init_entry = 2'(e); init_valid = 1'(v);
    init_tag = 20'(tag); init_ppn = 8'(p); init_rank = 2'(rank);
    for (int m = 0; m < 2; m++) begin
      bv[m][e] = v; btag[m][e] = tag; bppn[m][e] = p;
    end
    brank[0][e] = rank;
    blru[1][e / 2] = (rank != 0) ? e % 2 : 1 - (e % 2);
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic lookup(input int m, input logic [31:0] addr, input string tag);
    int ec, ep, expa;
    model(m, int'(addr[31:12]), ec, ep);
    expa = (ec == 2) ? 0 : (ep * 4096) + int'(addr[11:0]);
    @(negedge clk);
    rv[m] = 1'b1; va[m] = addr;
    @(negedge clk);
    rv[m] = 1'b0;
    if (ec == 0) begin
      chk({"R2 hit strobe ", tag}, int'(rspv[m]), 1);
      chk({"R2 hit code ", tag}, int'(code[m]), 0);
      chk({"R5 hit address ", tag}, int'(pa[m]), expa);
    end else begin
      chk({"R3 busy no response ", tag}, int'(rspv[m]), 0);
      chk({"R3 busy not ready ", tag}, int'(rdy[m]), 0);
      rv[m] = 1'b1; va[m] = addr ^ 32'h0000_5000;
      @(negedge clk);
      rv[m] = 1'b0;
      chk({"R3 miss strobe ", tag}, int'(rspv[m]), 1);
      chk({(ec == 1) ? "R3 table-hit code " : "R4 fault code ", tag}, int'(code[m]), ec);
      chk({(ec == 1) ? "R5 refill address " : "R4 fault address ", tag}, int'(pa[m]), expa);
      @(negedge clk);
      chk({"R10 decoy ignored ", tag}, int'(rspv[m]), 0);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] stream [6];
    for (int m = 0; m < 2; m++) begin
      rv[m] = 1'b0; va[m] = '0; blru[m][0] = 1; blru[m][1] = 1;
      for (int i = 0; i < 4; i++) begin
        bv[m][i] = 0; btag[m][i] = 0; bppn[m][i] = 0; brank[m][i] = i;
      end
    end
    for (int i = 0; i < 16; i++) begin ptv[i] = 0; ptp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1 reset strobe", int'(rspv[m]), 0);
      chk("R1 reset ready", int'(rdy[m]), 1);
      lookup(m, 32'h0000_2abc, "R1");
    end
    pt_load(0, 1, 5);  pt_load(3, 1, 6);  pt_load(4, 1, 9);  pt_load(5, 1, 11);
    pt_load(7, 1, 4);  pt_load(10, 1, 3); pt_load(11, 1, 12);
    init_ent(0, 1, 11, 12, 0); init_ent(1, 1, 7, 4, 1);
    init_ent(2, 1, 3, 6, 2);   init_ent(3, 1, 4, 9, 3);
    lookup(0, 32'h0000_b123, "R9");
    lookup(1, 32'h0000_6456, "R7 R9");
    stream[0] = 32'd4095; stream[1] = 32'd31272; stream[2] = 32'd15789;
    stream[3] = 32'd15000; stream[4] = 32'd4096; stream[5] = 32'd8190;
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 6; k++) lookup(m, stream[k], (m == 0) ? "R6" : "R7");
    pt_load(1, 1, 77);
    lookup(0, 32'h0000_1fff, "R11");
    lookup(1, 32'h0000_1001, "R11");
    lookup(0, 32'h0001_2000, "R8");
    lookup(1, 32'h0001_3000, "R8");
    for (int k = 0; k < 240; k++) begin
      logic [31:0] a;
      a = (32'((k * 7 + 3) % 20) << 12) | 32'((k * 373) % 4096);
      if (k % 9 == 0) pt_load(k % 16, (k / 9) % 3 != 2 ? 1 : 0, (k * 13) % 256);
      if (k % 40 == 17) init_ent(k % 4, 1, (k * 5) % 10, (k * 3) % 256, brank[0][k % 4]);
      for (int m = 0; m < 2; m++) lookup(m, a, (m == 0) ? "R6 sweep" : "R7 sweep");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule